// File: doc/BRIEF.md
# Greedy Cache Configuration Search Engine

This block searches the configuration space of a single configurable cache level for the lowest-energy setting. Each trial places a candidate configuration on its outputs and raises a one-cycle trial strobe. The environment then runs the workload on that configuration and returns an unsigned energy figure with a valid strobe. The engine keeps the cheapest configuration seen so far. It tunes the three cache parameters one at a time, always in the same order: total capacity first, then line length, then number of ways.

The search is greedy. For each parameter it starts from the best configuration found so far and raises that parameter one step. It keeps stepping only while each step strictly lowers the energy. The first step that does not help ends the sweep for that parameter. A full search therefore evaluates between four and seven configurations, not the whole space. When the last sweep ends, the engine raises a done flag and holds the winning configuration and its energy on the outputs until a new search is started.

Top module: `cache_tune_fsm`

## Requirements
- R1: While reset is held, and until the first start, done and trial_start are low, trial_count and best_energy are zero, and all three configuration codes are zero.
- R2: Each parameter uses a 2-bit code where 0, 1 and 2 select the smallest, middle and largest value. Capacity codes map to 2, 4 and 8 KB, line codes to 16, 32 and 64 bytes, and way codes to 1, 2 and 4 ways. A start from idle or done makes the first trial all-zero, and trial_start is high for exactly one cycle per trial.
- R3: After the base trial, the capacity code is raised to 1. It is raised to 2 only if the code-1 trial gave a strictly lower energy than the best so far.
- R4: The line sweep starts from the best configuration found so far with the line code set to 1. The line code is raised to 2 only if the code-1 trial strictly lowered the energy.
- R5: The way sweep starts from the best configuration found so far with the way code set to 1. The way code is raised to 2 only if the code-1 trial strictly lowered the energy. After this sweep the search ends.
- R6: An energy equal to or higher than the best so far is not an improvement. It leaves the best unchanged and ends the current sweep, so best_energy never rises during a search.
- R7: When the search ends, done goes high one cycle after the last energy is accepted. The configuration outputs then show the best configuration and best_energy its energy, and all of these stay unchanged until the next start.
- R8: trial_count is cleared by a start and counts the trials issued so far. At a trial strobe it equals the number of earlier trials in this search, and it never exceeds seven.
- R9: energy_valid is ignored unless the engine is waiting for a result. This includes the cycle of the trial strobe and the time while idle or done.
- R10: start is ignored while a search is in progress.
- R11: trial_start and done are never high together, and no output strobe is raised while a result is awaited.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a new search (accepted only when idle or done) |
| energy_valid | input | 1 | Energy result for the current trial is present |
| energy_in | input | EW | Unsigned energy of the current trial |
| trial_start | output | 1 | One-cycle strobe: evaluate the configuration on cfg_* |
| cfg_size | output | 2 | Capacity code of the current trial, or of the best once done |
| cfg_line | output | 2 | Line-length code of the current trial, or of the best once done |
| cfg_assoc | output | 2 | Way-count code of the current trial, or of the best once done |
| done | output | 1 | Search finished; held until the next start |
| best_energy | output | EW | Lowest energy accepted so far in this search |
| trial_count | output | CNT_W | Number of trials issued in this search |

## Verification
Four energy landscapes are applied.

The first improves monotonically along every parameter. It checks that each sweep runs to its last value and that the search takes seven trials.

The second is flat. Every trial ties with the base, so it separates a strict comparison from a less-than-or-equal one and ends after four trials with the base kept.

The third peaks in the middle of the capacity range, improves along line length, and then stops halfway through the way sweep. It shows that each sweep restarts from the best configuration so far and not from the last one tried.

The fourth improves only capacity and ways, with a worse line step between them. Stray energy strobes and a start pulse in mid-search are added to runs of these landscapes to show that both are ignored. Each search is checked trial by trial against a greedy model kept in the bench.

// File: rtl/tune_pkg.sv
package tune_pkg;

  // Number of independently tuned cache parameters (capacity, line, ways)
  localparam int unsigned N_AXES = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } tune_st_e;

  // Search order is behaviour: capacity, then line, then ways
  typedef enum logic [1:0] {
    AX_SIZE  = 2'd0,
    AX_LINE  = 2'd1,
    AX_ASSOC = 2'd2
  } tune_axis_e;

endpackage

// File: rtl/tune_rst_sync.sv
module tune_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/tune_next.sv
// Raises one parameter code of a configuration by one step.
module tune_next #(
  parameter int unsigned CODE_W = 2,
  parameter int unsigned MAXC   = 2
) (
  input  logic [tune_pkg::N_AXES-1:0][CODE_W-1:0] base_cfg,
  input  tune_pkg::tune_axis_e                      axis,
  output logic [tune_pkg::N_AXES-1:0][CODE_W-1:0] bumped_cfg,
  output logic                                      at_max
);

  for (genvar g = 0; g < int'(tune_pkg::N_AXES); g++) begin : g_axis
    assign bumped_cfg[g] = (int'(axis) == g) ? base_cfg[g] + 1'b1 : base_cfg[g];
  end

  assign at_max = (base_cfg[axis] == CODE_W'(MAXC));

endmodule

// File: rtl/tune_best.sv
// Holds the cheapest configuration and its energy.
module tune_best #(
  parameter int unsigned EW     = 16,
  parameter int unsigned CODE_W = 2
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      load,
  input  logic [EW-1:0]                             e_in,
  input  logic [tune_pkg::N_AXES-1:0][CODE_W-1:0] cfg_in,
  output logic [EW-1:0]                             best_e,
  output logic [tune_pkg::N_AXES-1:0][CODE_W-1:0] best_cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_e   <= '0;
      best_cfg <= '0;
    end else if (load) begin
      best_e   <= e_in;
      best_cfg <= cfg_in;
    end
  end

endmodule

// File: rtl/tune_count.sv
// Saturating trial counter with synchronous clear.
module tune_count #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (inc && (cnt != '1))   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/cache_tune_fsm.sv
module cache_tune_fsm #(
  parameter int unsigned EW     = 16,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned LEVELS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       energy_valid,
  input  logic [EW-1:0]              energy_in,
  output logic                       trial_start,
  output logic [$clog2(LEVELS)-1:0]  cfg_size,
  output logic [$clog2(LEVELS)-1:0]  cfg_line,
  output logic [$clog2(LEVELS)-1:0]  cfg_assoc,
  output logic                       done,
  output logic [EW-1:0]              best_energy,
  output logic [CNT_W-1:0]           trial_count
);

  import tune_pkg::*;

  localparam int unsigned CODE_W = $clog2(LEVELS);
  localparam int unsigned MAXC   = LEVELS - 1;

  typedef logic [N_AXES-1:0][CODE_W-1:0] cfg_t;

  logic       rst_n_s;
  tune_st_e   st_q, st_n;
  tune_axis_e axis_q, axis_n, axis_nx;
  cfg_t       cur_q, cur_n;
  logic       first_q, first_n;

  cfg_t       best_cfg, merged_best, cur_bump, adv_bump;
  logic [EW-1:0] best_e;
  logic       better, cur_at_max, adv_at_max_unused;
  logic       best_ld, cnt_clr, cnt_inc;

  tune_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // Compare result of the waiting trial against the running best
  assign better      = first_q || (energy_in < best_e);
  assign merged_best = better ? cur_q : best_cfg;

  always_comb begin
    case (axis_q)
      AX_SIZE: axis_nx = AX_LINE;
      AX_LINE: axis_nx = AX_ASSOC;
      default: axis_nx = AX_ASSOC;
    endcase
  end

  // Next step along the parameter being swept
  tune_next #(.CODE_W(CODE_W), .MAXC(MAXC)) i_next_cur (
    .base_cfg   (merged_best),
    .axis       (axis_q),
    .bumped_cfg (cur_bump),
    .at_max     (cur_at_max)
  );

  // First step along the following parameter
  tune_next #(.CODE_W(CODE_W), .MAXC(MAXC)) i_next_adv (
    .base_cfg   (merged_best),
    .axis       (axis_nx),
    .bumped_cfg (adv_bump),
    .at_max     (adv_at_max_unused)
  );

  tune_best #(.EW(EW), .CODE_W(CODE_W)) i_best (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (best_ld),
    .e_in     (energy_in),
    .cfg_in   (cur_q),
    .best_e   (best_e),
    .best_cfg (best_cfg)
  );

  tune_count #(.W(CNT_W)) i_count (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (trial_count)
  );

  // Next-state logic
  always_comb begin
    st_n    = st_q;
    cur_n   = cur_q;
    axis_n  = axis_q;
    first_n = first_q;
    best_ld = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          st_n    = ST_ISSUE;
          cur_n   = '0;
          axis_n  = AX_SIZE;
          first_n = 1'b1;
          cnt_clr = 1'b1;
        end
      end
      ST_ISSUE: begin
        cnt_inc = 1'b1;
        st_n    = ST_WAIT;
      end
      ST_WAIT: begin
        if (energy_valid) begin
          first_n = 1'b0;
          best_ld = better;
          if (better && !cur_at_max) begin
            cur_n = cur_bump;
            st_n  = ST_ISSUE;
          end else if (axis_q == AX_ASSOC) begin
            cur_n = merged_best;
            st_n  = ST_DONE;
          end else begin
            cur_n  = adv_bump;
            axis_n = axis_nx;
            st_n   = ST_ISSUE;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      axis_q  <= AX_SIZE;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cur_q   <= cur_n;
      axis_q  <= axis_n;
      first_q <= first_n;
    end
  end

  assign trial_start = (st_q == ST_ISSUE);
  assign done        = (st_q == ST_DONE);
  assign cfg_size    = cur_q[AX_SIZE];
  assign cfg_line    = cur_q[AX_LINE];
  assign cfg_assoc   = cur_q[AX_ASSOC];
  assign best_energy = best_e;

endmodule

// File: rtl/tune_chk.sv
module tune_chk #(
  parameter int unsigned EW     = 16,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned LEVELS = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic                      trial_start,
  input logic                      done,
  input logic [$clog2(LEVELS)-1:0] cfg_size,
  input logic [$clog2(LEVELS)-1:0] cfg_line,
  input logic [$clog2(LEVELS)-1:0] cfg_assoc,
  input logic [EW-1:0]             best_energy,
  input logic [CNT_W-1:0]          trial_count
);

  localparam int unsigned MAX_TRIALS = 1 + tune_pkg::N_AXES * (LEVELS - 1);

  // R11
  no_pulse_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trial_start && done));

  // R11
  pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trial_start |=> !trial_start);

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R7
  best_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(cfg_size) && $stable(cfg_line)
                          && $stable(cfg_assoc) && $stable(best_energy)));

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trial_start |=> (trial_count == $past(trial_count) + 1'b1));

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trial_count <= CNT_W'(MAX_TRIALS));

  // R6
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_count > CNT_W'(1)) |=> (best_energy <= $past(best_energy)));

  // R2
  base_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_start && (trial_count == '0)) |-> (cfg_size == '0 && cfg_line == '0 && cfg_assoc == '0));

endmodule

bind cache_tune_fsm tune_chk #(.EW(EW), .CNT_W(CNT_W), .LEVELS(LEVELS)) i_tune_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .trial_start (trial_start),
  .done        (done),
  .cfg_size    (cfg_size),
  .cfg_line    (cfg_line),
  .cfg_assoc   (cfg_assoc),
  .best_energy (best_energy),
  .trial_count (trial_count)
);

// File: tb/test_cache_tune_fsm.sv
module test_cache_tune_fsm;

  localparam int EW = 16;
  localparam int CNT_W = 4;

  logic clk;
  logic rst_n;
  logic start;
  logic energy_valid;
  logic [EW-1:0] energy_in;
  logic trial_start;
  logic [1:0] cfg_size, cfg_line, cfg_assoc;
  logic done;
  logic [EW-1:0] best_energy;
  logic [CNT_W-1:0] trial_count;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // expected model state
  int exp_n;
  int exp_cfg [8];
  int best_code;
  int best_e_exp;

  cache_tune_fsm #(.EW(EW), .CNT_W(CNT_W), .LEVELS(3)) i_cache_tune_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .energy_valid (energy_valid),
    .energy_in    (energy_in),
    .trial_start  (trial_start),
    .cfg_size     (cfg_size),
    .cfg_line     (cfg_line),
    .cfg_assoc    (cfg_assoc),
    .done         (done),
    .best_energy  (best_energy),
    .trial_count  (trial_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int energy_of(input int pat, input int s, input int l, input int a);
    int e;
    case (pat)
      0: e = 1000 - 100 * (s + l + a);
      1: e = 500;
      2: begin
        e = 300 + 20 * (2 - l);
        e += (s == 1) ? 0 : 50;
        e += (a == 1) ? 0 : ((a == 0) ? 30 : 60);
      end
      default: begin
        e = (s == 0) ? 400 : ((s == 1) ? 300 : 350);
        e += (l == 0) ? 0 : 10;
        e += (a == 0) ? 50 : ((a == 1) ? 20 : 0);
      end
    endcase
    return e;
  endfunction

  function automatic int code_of(input int c [3]);
    return c[0] * 100 + c[1] * 10 + c[2];
  endfunction

  // Greedy search model built from the requirements
  task automatic build_model(input int pat);
    int best [3];
    int cand [3];
    int e;
    best = '{0, 0, 0};
    best_e_exp = energy_of(pat, 0, 0, 0);
    exp_n = 0;
    exp_cfg[exp_n++] = 0;
    for (int p = 0; p < 3; p++) begin
      for (int v = 1; v <= 2; v++) begin
        cand = best;
        cand[p] = v;
        exp_cfg[exp_n++] = code_of(cand);
        e = energy_of(pat, cand[0], cand[1], cand[2]);
        if (e < best_e_exp) begin
          best = cand;
          best_e_exp = e;
        end else begin
          break;
        end
      end
    end
    best_code = code_of(best);
  endtask

  function automatic int out_code();
    return int'(cfg_size) * 100 + int'(cfg_line) * 10 + int'(cfg_assoc);
  endfunction

  task automatic run(input int pat, input int d, input bit inj_iss, input bit inj_start,
                     input string tag);
    int c [3];
    int held_cfg;
    int held_e;
    build_model(pat);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < exp_n; i++) begin
      chk(trial_start === 1'b1, "R2 trial strobe", int'(trial_start), 1);
      chk(out_code() == exp_cfg[i], "R2,R3,R4,R5 trial config", out_code(), exp_cfg[i]);
      chk(int'(trial_count) == i, "R8 count at strobe", int'(trial_count), i);
      chk(done === 1'b0, "R11 done during search", int'(done), 0);
      if (inj_iss && i == 1) begin
        energy_valid = 1'b1;   // R9: arrives on the strobe cycle, must be ignored
        energy_in = '0;
      end
      for (int k = 0; k < d; k++) begin
        @(negedge clk);
        energy_valid = 1'b0;
        start = (inj_start && i == 2 && k == 0);   // R10 mid-search start
        chk(trial_start === 1'b0 && done === 1'b0, "R11 quiet while waiting",
            int'({trial_start, done}), 0);
      end
      c[0] = exp_cfg[i] / 100;
      c[1] = (exp_cfg[i] / 10) % 10;
      c[2] = exp_cfg[i] % 10;
      start = 1'b0;
      energy_valid = 1'b1;
      energy_in = EW'(energy_of(pat, c[0], c[1], c[2]));
      @(negedge clk);
      energy_valid = 1'b0;
    end
    chk(done === 1'b1, {tag, " R7 done raised"}, int'(done), 1);
    chk(out_code() == best_code, {tag, " R7 best config"}, out_code(), best_code);
    chk(int'(best_energy) == best_e_exp, {tag, " R7 best energy"}, int'(best_energy), best_e_exp);
    chk(int'(trial_count) == exp_n, "R8 final count", int'(trial_count), exp_n);
    // R9: energy strobe while done must not disturb the result
    held_cfg = out_code();
    held_e = int'(best_energy);
    energy_valid = 1'b1;
    energy_in = '0;
    @(negedge clk);
    energy_valid = 1'b0;
    @(negedge clk);
    chk(int'(best_energy) == held_e, "R9 energy ignored when done", int'(best_energy), held_e);
    chk(out_code() == held_cfg, "R9 config kept when done", out_code(), held_cfg);
    chk(done === 1'b1, "R7 done held", int'(done), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    energy_valid = 1'b0;
    energy_in = '0;
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && trial_start === 1'b0, "R1 strobes in reset", int'({done, trial_start}), 0);
    chk(trial_count === '0 && best_energy === '0, "R1 counters in reset",
        int'(trial_count) + int'(best_energy), 0);
    chk(out_code() == 0, "R1 config in reset", out_code(), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done === 1'b0 && trial_start === 1'b0, "R1 idle after reset", int'({done, trial_start}), 0);

    run(0, 1, 1'b0, 1'b0, "R3 monotone");
    run(1, 3, 1'b1, 1'b0, "R6 flat ties R9");
    run(2, 2, 1'b0, 1'b1, "R4 peaked R10");
    run(3, 1, 1'b0, 1'b0, "R5 mixed");
    run(0, 2, 1'b1, 1'b1, "R2 restart");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule